// File: doc/BRIEF.md
# Flash Unlock Command Sequencer

This block sits behind the byte-wide write and read ports of a flash array and turns multi-write unlock sequences into internal operations. Each write carries a 19-bit address and a data byte. A state machine matches those writes against the expected unlock steps. When a sequence is complete, the block sends one request to a behavioural array model: program a byte, erase the whole chip, erase one 64 KB sector, or erase one 4 KB page. A three-write sequence instead switches reads into identification mode, where two fixed addresses return a manufacturer code and a device code.

While an operation runs, the block is busy and every read returns a status byte instead of array contents. Bit 7 of that byte is the complement of the final value of bit 7. Bit 6 flips on every read. Software polls either bit to learn when the operation has finished. The array model is kept small: it stores, for each of the 128 pages of 4 KB, only the bytes selected by the two lowest address bits.

State machine states, in order of the unlock steps:
- `S_IDLE`: no step matched yet.
- `S_UNLK1`: AAh was written to 5555h.
- `S_UNLK2`: 55h was written to 2AAAh.
- `S_PROG_ARM`: A0h was written to 5555h; the next write is the program target.
- `S_ERS_3`: 80h was written to 5555h.
- `S_ERS_4`: a second AAh was written to 5555h.
- `S_ERS_5`: a second 55h was written to 2AAAh; the next write is the erase terminator.

Transitions:
- `S_IDLE`→`S_UNLK1`: AAh at 5555h.
- `S_UNLK1`→`S_UNLK2`: 55h at 2AAAh.
- `S_UNLK2`→`S_PROG_ARM`: A0h at 5555h.
- `S_UNLK2`→`S_ERS_3`: 80h at 5555h.
- `S_UNLK2`→`S_IDLE`: 90h at 5555h, which also enters identification mode.
- `S_PROG_ARM`→`S_IDLE`: any write, which issues a program request.
- `S_ERS_3`→`S_ERS_4`: AAh at 5555h.
- `S_ERS_4`→`S_ERS_5`: 55h at 2AAAh.
- `S_ERS_5`→`S_IDLE`: issues an erase request on any of the three terminators. These are 10h at 5555h for the chip, 30h at a sector address, and 50h at a page address.
- Any state→`S_IDLE`: any other write. An F0h write also leaves identification mode, except when it is the program target.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `busy` and `rd_valid` are 0, the state machine is in `S_IDLE`, identification mode is off, and every array byte reads FFh.
- R2: The writes AAh@5555h, 55h@2AAAh, A0h@5555h, then (A,D) program the byte at A.
  - The stored byte becomes old AND D.
  - `busy` is 1 in the cycle after the target write is sampled.
  - The model stores one byte per pair (A[18:12], A[1:0]).
- R3: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h set every array byte to FFh.
- R4: The same five-write prefix followed by 30h at address A erases only the bytes whose A[18:16] matches. Sector 7 is the boot sector.
- R5: The same prefix followed by 50h at address A erases only the bytes whose A[18:12] matches, which is one 4 KB page.
- R6: AAh@5555h, 55h@2AAAh, 90h@5555h enters identification mode. There, address 0 reads `MFR_CODE`, address 1 reads `DEV_CODE`, and other addresses read the array.
- R7: A write of F0h to any address, outside the program-target step, leaves identification mode.
- R8: A write that does not match the next expected step returns the machine to `S_IDLE` without issuing any request.
- R9: Writes sampled while `busy` is 1 change neither the state machine nor the array.
- R10: A read while `busy` is 1 returns a status byte with the complement of the final bit 7 in bit 7 and zeros in bits 5:0. For an erase, the final bit 7 is 1.
- R11: Bit 6 of the status byte is the inverse of an internal toggle bit, which resets to 0. The toggle bit flips on each read while busy and holds otherwise, so the first busy read after reset returns bit 6 = 1.
- R12: `rd_data` and a one-cycle `rd_valid` pulse appear in the cycle after `rd_en` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one transaction per cycle |
| wr_addr | input | 19 | Write address |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | Read request |
| rd_addr | input | 19 | Read address |
| rd_data | output | 8 | Read result or status byte |
| rd_valid | output | 1 | Read result valid |
| busy | output | 1 | Operation pending or running |

## Verification
The hardest situation to reach is a full command sequence arriving while an operation is still running. Because those writes are ignored, the sequence leaves no trace in the state machine or the array. The stimulus starts a chip erase, which keeps the block busy for hundreds of cycles. Without waiting, it issues a complete program sequence. After the erase finishes, a read at the program target must return FFh. Two mismatch cases are also driven mid-sequence, and each is followed by the remaining steps of a program command. The target byte must stay unchanged, which shows that the partial sequence was discarded.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_UNLK1,
        S_UNLK2,
        S_PROG_ARM,
        S_ERS_3,
        S_ERS_4,
        S_ERS_5
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_PROG,
        OP_CHIP,
        OP_SECT,
        OP_PAGE
    } op_kind_t;

    localparam logic [15:0] UNLK_ADR1 = 16'h5555;
    localparam logic [15:0] UNLK_ADR2 = 16'h2AAA;
    localparam logic [7:0]  KEY_A     = 8'hAA;
    localparam logic [7:0]  KEY_B     = 8'h55;
    localparam logic [7:0]  CMD_PROG  = 8'hA0;
    localparam logic [7:0]  CMD_ERASE = 8'h80;
    localparam logic [7:0]  CMD_ID    = 8'h90;
    localparam logic [7:0]  CMD_EXIT  = 8'hF0;
    localparam logic [7:0]  TERM_CHIP = 8'h10;
    localparam logic [7:0]  TERM_SECT = 8'h30;
    localparam logic [7:0]  TERM_PAGE = 8'h50;

endpackage

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int PAGE_LSB = 12,
    parameter int COL_W    = 2,
    localparam int IDX_W   = ADDR_W - PAGE_LSB + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              busy_i,
    output logic              op_req,
    output op_kind_t          op_kind,
    output logic [IDX_W-1:0]  op_idx,
    output logic [7:0]        op_data,
    output logic              id_mode
);

    localparam logic [ADDR_W-1:0] ADR1 = ADDR_W'(UNLK_ADR1);
    localparam logic [ADDR_W-1:0] ADR2 = ADDR_W'(UNLK_ADR2);

    seq_state_t state_q, state_d;
    logic       take, issue, id_set, id_clr;
    op_kind_t   kind_d;
    logic       at1_a, at2_b;

    assign take  = wr_en && !busy_i && !op_req;
    assign at1_a = (wr_addr == ADR1) && (wr_data == KEY_A);
    assign at2_b = (wr_addr == ADR2) && (wr_data == KEY_B);

    always_comb begin
        state_d = state_q;
        issue   = 1'b0;
        kind_d  = OP_PROG;
        id_set  = 1'b0;
        id_clr  = 1'b0;
        if (take) begin
            state_d = S_IDLE;
            if (wr_data == CMD_EXIT && state_q != S_PROG_ARM) begin
                id_clr = 1'b1;
            end else begin
                unique case (state_q)
                    S_IDLE:  if (at1_a) state_d = S_UNLK1;
                    S_UNLK1: if (at2_b) state_d = S_UNLK2;
                    S_UNLK2: begin
                        if (wr_addr == ADR1) begin
                            if (wr_data == CMD_PROG)       state_d = S_PROG_ARM;
                            else if (wr_data == CMD_ERASE) state_d = S_ERS_3;
                            else if (wr_data == CMD_ID)    id_set  = 1'b1;
                        end
                    end
                    S_PROG_ARM: begin
                        issue  = 1'b1;
                        kind_d = OP_PROG;
                    end
                    S_ERS_3: if (at1_a) state_d = S_ERS_4;
                    S_ERS_4: if (at2_b) state_d = S_ERS_5;
                    S_ERS_5: begin
                        if (wr_data == TERM_CHIP && wr_addr == ADR1) begin
                            issue = 1'b1; kind_d = OP_CHIP;
                        end else if (wr_data == TERM_SECT) begin
                            issue = 1'b1; kind_d = OP_SECT;
                        end else if (wr_data == TERM_PAGE) begin
                            issue = 1'b1; kind_d = OP_PAGE;
                        end
                    end
                    default: state_d = S_IDLE;
                endcase
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_req  <= 1'b0;
            op_kind <= OP_PROG;
            op_idx  <= '0;
            op_data <= 8'h00;
            id_mode <= 1'b0;
        end else begin
            op_req <= issue;
            if (issue) begin
                op_kind <= kind_d;
                op_idx  <= {wr_addr[ADDR_W-1:PAGE_LSB], wr_addr[COL_W-1:0]};
                op_data <= wr_data;
            end
            if (id_set)      id_mode <= 1'b1;
            else if (id_clr) id_mode <= 1'b0;
        end
    end

    // R9: a write while the array is busy leaves the sequence untouched
    a_r9_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy_i) |=> ($stable(state_q) && !op_req));

    // R8: a mismatch at the second unlock step drops back to idle with no request
    a_r8_mismatch_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (take && state_q == S_UNLK1 && !at2_b) |=> (state_q == S_IDLE && !op_req));

    // R2: each completed sequence raises exactly one single-cycle request
    a_r2_single_request: assert property (@(posedge clk) disable iff (!rst_n)
        op_req |=> !op_req);

endmodule

// File: rtl/flash_array_model.sv
module flash_array_model
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int PAGE_LSB = 12,
    parameter int SECT_LSB = 16,
    parameter int COL_W    = 2,
    parameter int PROG_LAT = 6,
    localparam int IDX_W   = ADDR_W - PAGE_LSB + COL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  op_kind_t         kind_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [7:0]       data_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic             busy_o,
    output logic             pend_b7_o,
    output logic [7:0]       rd_byte_o
);

    localparam int DEPTH     = 1 << IDX_W;
    localparam int SECT_BITS = ADDR_W - SECT_LSB;
    localparam int LIM       = (DEPTH > PROG_LAT) ? DEPTH : PROG_LAT;
    localparam int CNT_W     = $clog2(LIM + 1);

    logic [7:0]       mem_q [DEPTH];
    logic             busy_q;
    op_kind_t         kind_q;
    logic [IDX_W-1:0] idx_q;
    logic [7:0]       data_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] walk;
    logic             hit;

    assign walk = cnt_q[IDX_W-1:0];

    always_comb begin
        unique case (kind_q)
            OP_CHIP: hit = 1'b1;
            OP_SECT: hit = (walk[IDX_W-1 -: SECT_BITS] == idx_q[IDX_W-1 -: SECT_BITS]);
            OP_PAGE: hit = (walk[IDX_W-1:COL_W] == idx_q[IDX_W-1:COL_W]);
            default: hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
            busy_q <= 1'b0;
            kind_q <= OP_PROG;
            idx_q  <= '0;
            data_q <= 8'h00;
            cnt_q  <= '0;
        end else if (!busy_q) begin
            if (req_i) begin
                busy_q <= 1'b1;
                kind_q <= kind_i;
                idx_q  <= idx_i;
                data_q <= data_i;
                cnt_q  <= '0;
            end
        end else if (kind_q == OP_PROG) begin
            if (cnt_q == CNT_W'(PROG_LAT - 1)) begin
                mem_q[idx_q] <= mem_q[idx_q] & data_q;
                busy_q       <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            if (hit) mem_q[walk] <= 8'hFF;
            if (cnt_q == CNT_W'(DEPTH - 1)) busy_q <= 1'b0;
            else                            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign busy_o    = busy_q;
    assign rd_byte_o = mem_q[rd_idx_i];

    always_comb begin
        if (busy_q)
            pend_b7_o = (kind_q == OP_PROG) ? (mem_q[idx_q][7] & data_q[7]) : 1'b1;
        else
            pend_b7_o = (kind_i == OP_PROG) ? (mem_q[idx_i][7] & data_i[7]) : 1'b1;
    end

    // R2: an accepted request makes the array busy on the next cycle
    a_r2_req_starts_busy: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> busy_q);

    // R9: requests only arrive while the array is idle
    a_r9_req_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |-> !busy_q);

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen #(
    parameter int          ADDR_W   = 19,
    parameter logic [7:0]  MFR_CODE = 8'hDA,
    parameter logic [7:0]  DEV_CODE = 8'h3D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              busy_i,
    input  logic              pend_b7_i,
    input  logic              id_mode_i,
    input  logic [7:0]        arr_byte_i,
    output logic [7:0]        rd_data,
    output logic              rd_valid
);

    logic tog_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_q    <= 1'b0;
            rd_data  <= 8'h00;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                if (busy_i) begin
                    rd_data <= {~pend_b7_i, ~tog_q, 6'b000000};
                    tog_q   <= ~tog_q;
                end else if (id_mode_i && rd_addr == ADDR_W'(0)) begin
                    rd_data <= MFR_CODE;
                end else if (id_mode_i && rd_addr == ADDR_W'(1)) begin
                    rd_data <= DEV_CODE;
                end else begin
                    rd_data <= arr_byte_i;
                end
            end
        end
    end

    // R12: one-cycle read latency
    a_r12_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R11: toggle flips on busy reads and holds otherwise
    a_r11_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy_i) |=> (tog_q != $past(tog_q)));
    a_r11_toggle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && busy_i) |=> $stable(tog_q));

    // R10: low status bits are zero
    a_r10_status_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy_i) |=> (rd_data[5:0] == 6'b000000));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int          ADDR_W   = 19,
    parameter int          PAGE_LSB = 12,
    parameter int          SECT_LSB = 16,
    parameter int          COL_W    = 2,
    parameter int          PROG_LAT = 6,
    parameter logic [7:0]  MFR_CODE = 8'hDA,
    parameter logic [7:0]  DEV_CODE = 8'h3D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              busy
);

    localparam int IDX_W = ADDR_W - PAGE_LSB + COL_W;

    logic             cmd_req;
    op_kind_t         cmd_kind;
    logic [IDX_W-1:0] cmd_idx;
    logic [7:0]       cmd_data;
    logic             id_mode;
    logic             arr_busy;
    logic             pend_b7;
    logic [7:0]       arr_byte;
    logic [IDX_W-1:0] rd_idx;

    assign rd_idx = {rd_addr[ADDR_W-1:PAGE_LSB], rd_addr[COL_W-1:0]};
    assign busy   = arr_busy | cmd_req;

    flash_cmd_decoder #(
        .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .COL_W(COL_W)
    ) u_dec (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy_i(arr_busy),
        .op_req(cmd_req), .op_kind(cmd_kind), .op_idx(cmd_idx),
        .op_data(cmd_data), .id_mode(id_mode)
    );

    flash_array_model #(
        .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .SECT_LSB(SECT_LSB),
        .COL_W(COL_W), .PROG_LAT(PROG_LAT)
    ) u_arr (
        .clk(clk), .rst_n(rst_n),
        .req_i(cmd_req), .kind_i(cmd_kind), .idx_i(cmd_idx), .data_i(cmd_data),
        .rd_idx_i(rd_idx),
        .busy_o(arr_busy), .pend_b7_o(pend_b7), .rd_byte_o(arr_byte)
    );

    flash_status_gen #(
        .ADDR_W(ADDR_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
    ) u_stat (
        .clk(clk), .rst_n(rst_n),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .busy_i(busy), .pend_b7_i(pend_b7), .id_mode_i(id_mode),
        .arr_byte_i(arr_byte),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // R1: nothing is pending straight after reset
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !busy);

endmodule

// File: tb/flash_cmd_seq_tb_top.sv
module flash_cmd_seq_tb_top;

    localparam int CLK_P = 10;
    localparam logic [7:0] MFR = 8'hDA;
    localparam logic [7:0] DEV = 8'h3D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [18:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [18:0] rd_addr = '0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        busy;

    always #(CLK_P/2) clk = ~clk;

    flash_cmd_seq dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] ref_mem [0:511];
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic tog = 1'b0;
    logic pend_b7 = 1'b1;
    logic id_on = 1'b0;
    logic last_busy;
    bit   done = 1'b0;

    function automatic int ix(input logic [18:0] a);
        return {a[18:12], a[1:0]};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [18:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [18:0] a, input string tag);
        logic [7:0] e;
        @(negedge clk);
        last_busy = busy;
        if (busy) begin
            tog = ~tog;
            e = {~pend_b7, tog, 6'b000000};
        end else if (id_on && a == 19'd0) e = MFR;
        else if (id_on && a == 19'd1)     e = DEV;
        else                              e = ref_mem[ix(a)];
        exp_q.push_back(e);
        tag_q.push_back(tag);
        rd_en = 1'b1; rd_addr = a;
        @(posedge clk);
        #1 rd_en = 1'b0;
    endtask

    task automatic wait_done(input logic [18:0] a, input string tag);
        do rd(a, tag); while (last_busy);
    endtask

    task automatic unlock(input logic [7:0] cmd);
        wr(19'h05555, 8'hAA);
        wr(19'h02AAA, 8'h55);
        wr(19'h05555, cmd);
    endtask

    task automatic prog(input logic [18:0] a, input logic [7:0] d, input bit acc, input string tag);
        unlock(8'hA0);
        wr(a, d);
        if (acc) begin
            ref_mem[ix(a)] = ref_mem[ix(a)] & d;
            pend_b7 = ref_mem[ix(a)][7];
            chk(tag, {7'd0, busy}, 8'd1);
        end
    endtask

    task automatic erase(input logic [18:0] a, input logic [7:0] term, input bit acc, input string tag);
        unlock(8'h80);
        wr(19'h05555, 8'hAA);
        wr(19'h02AAA, 8'h55);
        wr(a, term);
        if (acc) begin
            for (int i = 0; i < 512; i++) begin
                if (term == 8'h10 ||
                    (term == 8'h30 && i[8:6] == a[18:16]) ||
                    (term == 8'h50 && i[8:2] == a[18:12]))
                    ref_mem[i] = 8'hFF;
            end
            pend_b7 = 1'b1;
            chk(tag, {7'd0, busy}, 8'd1);
        end
    endtask

    // Monitor: pop expected results as the design presents them
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk("R12 unexpected rd_valid", 8'h01, 8'h00);
            end else begin
                chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 512; i++) ref_mem[i] = 8'hFF;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 busy after reset", {7'd0, busy}, 8'd0);
        chk("R1 rd_valid after reset", {7'd0, rd_valid}, 8'd0);
        rst_n = 1'b1;
        rd(19'h00100, "R1 R12 erased read");

        // R2 R10 R11: program with bit7 = 0, status bit7 = 1
        prog(19'h00100, 8'h5A, 1'b1, "R2 busy after program");
        wait_done(19'h00100, "R2 R10 R11 poll 5A");
        // bit7 = 1 target, then a second program ANDs
        prog(19'h01234, 8'hC3, 1'b1, "R2 busy after program C3");
        wait_done(19'h01234, "R2 R10 R11 poll C3");
        prog(19'h01234, 8'h0F, 1'b1, "R2 busy after program AND");
        wait_done(19'h01234, "R2 R10 poll AND result");

        // R6 R7 identification mode
        unlock(8'h90); id_on = 1'b1;
        rd(19'h00000, "R6 manufacturer code");
        rd(19'h00001, "R6 device code");
        rd(19'h00100, "R6 array read in id mode");
        wr(19'h12345, 8'hF0); id_on = 1'b0;
        rd(19'h00000, "R7 array after exit");
        rd(19'h00001, "R7 array after exit addr1");

        // R8 mismatches mid-sequence
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'h77);
        wr(19'h05555, 8'hA0); wr(19'h00200, 8'h00);
        chk("R8 no busy after mismatch", {7'd0, busy}, 8'd0);
        rd(19'h00200, "R8 byte untouched");
        wr(19'h05555, 8'hAA); wr(19'h01234, 8'h55);
        wr(19'h05555, 8'hA0); wr(19'h00300, 8'h00);
        chk("R8 no busy after bad address", {7'd0, busy}, 8'd0);
        rd(19'h00300, "R8 byte untouched 2");

        // R5 page erase
        prog(19'h73004, 8'h11, 1'b1, "R2 busy p1"); wait_done(19'h73004, "R2 poll p1");
        prog(19'h74008, 8'h22, 1'b1, "R2 busy p2"); wait_done(19'h74008, "R2 poll p2");
        prog(19'h75001, 8'h33, 1'b1, "R2 busy p3"); wait_done(19'h75001, "R2 poll p3");
        prog(19'h61000, 8'h44, 1'b1, "R2 busy p4"); wait_done(19'h61000, "R2 poll p4");
        erase(19'h73000, 8'h50, 1'b1, "R5 busy page erase");
        wait_done(19'h73004, "R5 R10 R11 poll page erase");
        rd(19'h74008, "R5 neighbour page kept");

        // R4 sector erase of boot sector
        erase(19'h74000, 8'h30, 1'b1, "R4 busy sector erase");
        wait_done(19'h74008, "R4 R10 poll sector erase");
        rd(19'h75001, "R4 same sector erased");
        rd(19'h61000, "R4 other sector kept");
        rd(19'h00100, "R4 low sector kept");

        // R3 chip erase, R9 writes during busy are dropped
        erase(19'h05555, 8'h10, 1'b1, "R3 busy chip erase");
        prog(19'h00400, 8'h00, 1'b0, "R9 ignored");
        wait_done(19'h00000, "R3 R11 poll chip erase");
        rd(19'h00400, "R9 write during busy dropped");
        rd(19'h00100, "R3 chip erased 1");
        rd(19'h61000, "R3 chip erased 2");
        prog(19'h00500, 8'h3C, 1'b1, "R9 machine idle after busy");
        wait_done(19'h00500, "R9 R11 program after erase");

        repeat (4) @(negedge clk);
        chk("R12 all reads returned", 8'(exp_q.size()), 8'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule